// File: doc/BRIEF.md
# Event Input Glitch Filter Bank

This block cleans up asynchronous event inputs before a timer counts them. Each channel first brings its raw pin into the system clock domain with a two-stage synchronizer. It then filters the synchronized level against a slow reference tick. The filtered output takes a new level only after the input has held that level for a fixed number of slow ticks, so short pulses of either polarity never reach the counter.

Each channel has its own mode bit. With the bit clear, the filter is bypassed and the synchronized input drives the output directly. Every channel also produces a single-cycle strobe on each falling edge of its output level, and a downstream timer uses that strobe as its count event. The bank holds a parameterized number of identical channels, four by default, all sharing one slow tick.

Top module: `nrj_bank`

## Requirements
- R1: During and right after reset, every channel's output level is high, its fall strobe is low and its filter mode bit reads as bypass.
- R2: With a channel's mode bit at 0, its output level equals the raw input as sampled two clock edges earlier.
- R3: With the mode bit at 1, a high or low pulse whose synchronized width covers fewer than 16 slow ticks leaves the output level unchanged.
- R4: With the mode bit at 1, a pulse covering 16 or more slow ticks reaches the output, and a 32-tick pulse always does.
- R5: With the mode bit at 1 and held, the output level changes only on a clock edge at which the slow tick is high.
- R6: Any return of the synchronized input to the current output level clears the tick count already gathered toward a change.
- R7: The fall strobe is high for exactly the one cycle after each high-to-low step of the output level and at no other time. It never fires on a rising step.
- R8: Each channel's mode bit acts only on that channel, so filtered and bypassed channels can run side by side on the same input.
- R9: While a channel is in bypass, its filter tracks the synchronized input. Switching to filter mode with a steady input then causes no output step and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow reference period |
| raw_in | input | NUM_CH | Asynchronous event inputs, one per channel |
| enable | input | NUM_CH | Per-channel mode: 1 filters, 0 bypasses |
| level_out | output | NUM_CH | Filtered (or bypassed) input level |
| fall_stb | output | NUM_CH | One-cycle strobe on each falling step of level_out |

## Verification
The hardest case to reach is a pulse that sits exactly on the threshold: 15 ticks must be rejected and 16 must pass. The input has to be held for a whole number of tick periods, and the tick phase relative to the pulse must not change the count. The stimulus drives each pulse for width×period clock cycles, so the pulse always contains exactly that many ticks whatever the phase. It sweeps the width through the threshold for both polarities, under two mode patterns, and adds a split pulse whose halves are each below the threshold.

// File: rtl/nrj_pkg.sv
package nrj_pkg;

    localparam int NRJ_HOLD_TICKS  = 16;
    localparam int NRJ_SYNC_STAGES = 2;

    typedef enum logic {
        NRJ_BYPASS = 1'b0,
        NRJ_FILTER = 1'b1
    } nrj_mode_e;

    typedef struct packed {
        logic lvl;
        logic fall;
    } nrj_out_t;

    function automatic int nrj_cnt_width(input int hold);
        int w;
        w = $clog2(hold);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/nrj_sync.sv
module nrj_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nrj_filter.sv
module nrj_filter
    import nrj_pkg::*;
#(
    parameter int HOLD = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  nrj_mode_e mode,
    input  logic      din,
    output logic      lvl
);
    localparam int            CW   = nrj_cnt_width(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] run;
    } filt_st_t;

    filt_st_t st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        if (mode == NRJ_BYPASS) begin
            st_nx.filt = din;
            st_nx.run  = '0;
        end else if (din == st_q.filt) begin
            st_nx.run = '0;
        end else if (tick) begin
            if (st_q.run == LAST) begin
                st_nx.filt = din;
                st_nx.run  = '0;
            end else begin
                st_nx.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{filt: 1'b1, run: '0};
        else     st_q <= st_nx;
    end

    assign lvl = (mode == NRJ_FILTER) ? st_q.filt : din;
endmodule

// File: rtl/nrj_edge.sv
module nrj_edge
    import nrj_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    output nrj_out_t res
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl;
    end

    assign res.lvl  = lvl;
    assign res.fall = prev_q & ~lvl;
endmodule

// File: rtl/nrj_bank.sv
module nrj_bank
    import nrj_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int HOLD_TICKS  = NRJ_HOLD_TICKS,
    parameter int SYNC_STAGES = NRJ_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [NUM_CH-1:0] enable,
    output logic [NUM_CH-1:0] level_out,
    output logic [NUM_CH-1:0] fall_stb
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic      sync_lvl;
        logic      filt_lvl;
        nrj_out_t  ch_res;
        nrj_mode_e mode;

        assign mode = nrj_mode_e'(enable[ch]);

        nrj_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) i_sync (
            .clk(clk),
            .rst(rst),
            .d  (raw_in[ch]),
            .q  (sync_lvl)
        );

        nrj_filter #(
            .HOLD(HOLD_TICKS)
        ) i_filter (
            .clk (clk),
            .rst (rst),
            .tick(slow_tick),
            .mode(mode),
            .din (sync_lvl),
            .lvl (filt_lvl)
        );

        nrj_edge i_edge (
            .clk(clk),
            .rst(rst),
            .lvl(filt_lvl),
            .res(ch_res)
        );

        assign level_out[ch] = ch_res.lvl;
        assign fall_stb[ch]  = ch_res.fall;
    end
endmodule

// File: rtl/nrj_bank_chk.sv
module nrj_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              slow_tick,
    input logic [NUM_CH-1:0] raw_in,
    input logic [NUM_CH-1:0] enable,
    input logic [NUM_CH-1:0] level_out,
    input logic [NUM_CH-1:0] fall_stb
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd2 && !enable[i]) |-> (level_out[i] == $past(raw_in[i], 2))) // R2
            else $error("bypass delay ch %0d", i);

        AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd1 && enable[i] && $past(enable[i]) && level_out[i] != $past(level_out[i]))
            |-> $past(slow_tick)) // R5
            else $error("step without tick ch %0d", i);

        AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd1 && fall_stb[i]) |-> ($past(level_out[i]) && !level_out[i])) // R7
            else $error("stray strobe ch %0d", i);

        AST_FALL_STROBED: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd1 && $past(level_out[i]) && !level_out[i]) |-> fall_stb[i]) // R7
            else $error("missed strobe ch %0d", i);

        AST_RESET_LEVEL: assert property (@(posedge clk)
            $past(rst) |-> (level_out[i] && !fall_stb[i])) // R1
            else $error("reset level ch %0d", i);
    end
endmodule

bind nrj_bank nrj_bank_chk #(.NUM_CH(NUM_CH)) i_nrj_bank_chk (
    .clk      (clk),
    .rst      (rst),
    .slow_tick(slow_tick),
    .raw_in   (raw_in),
    .enable   (enable),
    .level_out(level_out),
    .fall_stb (fall_stb)
);

// File: tb/test_nrj_bank.sv
module test_nrj_bank;
    localparam int NCH  = 4;
    localparam int PER  = 4;     // clock cycles per slow tick
    localparam int HOLD = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           slow_tick;
    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] enable;
    logic [NCH-1:0] level_out;
    logic [NCH-1:0] fall_stb;

    int n_vec  = 0;
    int n_fail = 0;
    int stb_cnt [NCH];
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    nrj_bank #(.NUM_CH(NCH), .HOLD_TICKS(HOLD)) i_nrj_bank (
        .clk      (clk),
        .rst      (rst),
        .slow_tick(slow_tick),
        .raw_in   (raw_in),
        .enable   (enable),
        .level_out(level_out),
        .fall_stb (fall_stb)
    );

    always #10 clk = ~clk;

    // values seen at the latest edges
    logic [NCH-1:0] raw_e1, raw_e2, en_e1, lvl_prev;
    logic           tick_e1;
    always @(posedge clk) begin
        raw_e2  <= raw_e1;
        raw_e1  <= raw_in;
        en_e1   <= enable;
        tick_e1 <= slow_tick;
    end

    task automatic chk(input string req, input int ch, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d actual=%0d expected=%0d at %0t", req, ch, act, exp, $time);
        end
    endtask

    // per-cycle checks against the requirements
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            for (int c = 0; c < NCH; c++) begin
                if (!enable[c] && !en_e1[c])
                    chk("R2 bypass delay", c, level_out[c], raw_e2[c]);
                if (enable[c] && en_e1[c] && level_out[c] != lvl_prev[c] && !tick_e1)
                    chk("R5 step off tick", c, 1, 0);
                chk("R7 strobe", c, fall_stb[c], lvl_prev[c] & ~level_out[c]);
                if (fall_stb[c]) stb_cnt[c]++;
            end
        end
        lvl_prev = level_out;
    end

    initial begin
        slow_tick = 1'b0;
        @(negedge rst);
        forever begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
            repeat (PER - 2) @(negedge clk);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cnt();
        for (int c = 0; c < NCH; c++) stb_cnt[c] = 0;
    endtask

    // idle level, then a pulse of w tick periods (optionally split by a 1-cycle return)
    task automatic episode(input int w, input bit idle, input logic [NCH-1:0] en, input bit split);
        string tag;
        int    exp;
        enable = en;
        raw_in = {NCH{idle}};
        wait_cyc(20 * PER + 4);
        clear_cnt();
        raw_in = {NCH{~idle}};
        wait_cyc(w * PER);
        if (split) begin
            raw_in = {NCH{idle}};
            wait_cyc(1);
            raw_in = {NCH{~idle}};
            wait_cyc(w * PER);
        end
        raw_in = {NCH{idle}};
        wait_cyc(20 * PER + 4);
        for (int c = 0; c < NCH; c++) begin
            if (split)         tag = "R6 restart";
            else if (w >= HOLD) tag = "R4 pass";
            else               tag = "R3 reject";
            if (en[c]) exp = (!split && w >= HOLD) ? 1 : 0;
            else       exp = split ? 2 : 1;
            if (en != {NCH{1'b1}}) tag = {tag, " R8 mixed"};
            chk(tag, c, stb_cnt[c], exp);
            chk("R4 settle", c, level_out[c], idle);
        end
    endtask

    initial begin
        rst    = 1'b1;
        raw_in = '1;
        enable = '0;
        wait_cyc(4);
        for (int c = 0; c < NCH; c++) begin
            chk("R1 reset level", c, level_out[c], 1);
            chk("R1 reset strobe", c, fall_stb[c], 0);
        end
        @(negedge clk) rst = 1'b0;
        lvl_prev = '1;
        mon_on   = 1'b1;
        wait_cyc(3);

        for (int pat = 0; pat < 2; pat++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int w = 1; w <= 18; w++)
                    episode(w, pol[0], pat == 0 ? 4'hF : 4'h5, 1'b0);
                episode(32, pol[0], pat == 0 ? 4'hF : 4'hA, 1'b0);
                episode(10, pol[0], pat == 0 ? 4'hF : 4'h5, 1'b1);
                episode(15, pol[0], 4'hF, 1'b1);
            end
        end

        // R9: switch to filter mode with a steady low input
        enable = '0;
        raw_in = '0;
        wait_cyc(10);
        clear_cnt();
        enable = '1;
        wait_cyc(3 * PER);
        for (int c = 0; c < NCH; c++) begin
            chk("R9 enable no step", c, level_out[c], 0);
            chk("R9 enable no strobe", c, stb_cnt[c], 0);
        end

        mon_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule